// File: doc/BRIEF.md
# Synapse Row Walker

The walker turns one packed connection pointer into a stream of synaptic events. A pointer word carries both where a run of synapse rows begins and how many rows the run spans. The walker reads those rows one at a time over a simple request/response memory port. It splits each 256-bit row into eight 32-bit entries and presents every entry that is meaningful on a valid/ready event stream.

An entry is either a weighted synapse, which names a target neuron and a signed or unsigned 16-bit weight, or a spike-output marker, which names a neuron index to report. Which kind an entry is follows from its top three bits. Entries that match neither form are dropped without a stall and counted. Once the final entry of the run has been consumed, the block raises a one-cycle completion pulse. It then accepts the next pointer.

Top module: `syn_row_walker`

## Requirements
- R1: After reset, `ptr_ready` is 1, `rd_req_valid`, `ev_valid` and `walk_done` are 0, and `skip_count` is 0.
- R2: A pointer's bits [31:23] give the row count and bits [22:0] the first row address. The walker issues exactly one read per row, to addresses start, start+1, … start+count-1, in that order.
- R3: A pointer with a row count of 0 issues no read, and `walk_done` pulses in the cycle after that pointer is accepted.
- R4: `ptr_ready` is 0 from the acceptance of a nonzero-count pointer until its walk completes.
- R5: Within a row, entries are consumed from lane 0 (row bits [31:0]) up to lane 7 (row bits [255:224]), and rows are consumed in read order.
- R6: An entry whose bits [31:29] equal 000 is emitted with `ev_kind`=0, `ev_target` = entry bits [28:16] zero-extended to 17 bits, and `ev_weight` = entry bits [15:0].
- R7: An entry whose bits [31:29] equal 100 and whose bits [28:17] are all zero is emitted with `ev_kind`=1, `ev_target` = entry bits [16:0], and `ev_weight`=0.
- R8: Any other entry produces no event, and `skip_count` rises by one for it (saturating at its maximum).
- R9: At most one read is outstanding. No read request is raised while an entry of the current row is still pending on the event stream.
- R10: While `ev_valid` is 1 and `ev_ready` is 0, the event and its fields hold steady in the next cycle.
- R11: `walk_done` is a single-cycle pulse in the cycle after the final entry of the last row is consumed (accepted downstream, or skipped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_valid | input | 1 | Pointer offered |
| ptr_ready | output | 1 | Walker idle and able to take a pointer |
| ptr_word | input | 32 | Packed pointer: row count and first row address |
| rd_req_valid | output | 1 | Row read request |
| rd_req_ready | input | 1 | Memory takes the request |
| rd_req_addr | output | 23 | Row address to read |
| rd_rsp_valid | input | 1 | Row data returned (one cycle) |
| rd_rsp_data | input | 256 | Returned row of eight entries |
| ev_valid | output | 1 | Event offered downstream |
| ev_ready | input | 1 | Downstream takes the event |
| ev_kind | output | 1 | 0 = weighted synapse, 1 = spike output |
| ev_target | output | 17 | Target neuron address or spike neuron index |
| ev_weight | output | 16 | Synaptic weight (0 for spike outputs) |
| walk_done | output | 1 | One-cycle pulse when a pointer's walk is complete |
| skip_count | output | 16 | Running count of dropped entries |

## Verification
The bench targets the case where a zero-count pointer arrives: a walker that treats 0 as 512 rows, or that waits for a read, would issue requests or never pulse completion. It places invalid opcodes and spike markers with stray middle bits between valid entries, which a loose decoder would emit as events. It throttles the event stream at random to catch a design that drops, repeats or reorders held entries, or that fetches the next row too early. It also starts a run near the low-address wrap of the test memory to confirm that row addresses step by one across rows, and it times the completion pulse against the last accepted event.

// File: rtl/swk_pkg.sv
package swk_pkg;

    localparam logic [2:0] OPC_SYN = 3'b000;
    localparam logic [2:0] OPC_SPK = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_EMIT = 2'd3
    } walk_st_e;

endpackage

// File: rtl/swk_entry_decode.sv
module swk_entry_decode
    import swk_pkg::*;
#(
    parameter int ENTRY_W = 32,
    parameter int TGT_W   = 17,
    parameter int WGT_W   = 16
) (
    input  logic [ENTRY_W-1:0] entry_i,
    output logic               is_syn_o,
    output logic               is_spk_o,
    output logic [TGT_W-1:0]   target_o,
    output logic [WGT_W-1:0]   weight_o
);
    localparam int OPC_LSB  = ENTRY_W - 3;
    localparam int SYN_AW   = OPC_LSB - WGT_W;

    logic [2:0]        opc;
    logic [SYN_AW-1:0] syn_addr;
    logic              mid_zero;

    always_comb begin
        opc      = entry_i[ENTRY_W-1:OPC_LSB];
        syn_addr = entry_i[OPC_LSB-1:WGT_W];
        mid_zero = (entry_i[OPC_LSB-1:TGT_W] == '0);
        is_syn_o = (opc == OPC_SYN);
        is_spk_o = (opc == OPC_SPK) && mid_zero;
        if (is_syn_o) begin
            target_o = TGT_W'(syn_addr);
            weight_o = entry_i[WGT_W-1:0];
        end else begin
            target_o = entry_i[TGT_W-1:0];
            weight_o = '0;
        end
    end
endmodule

// File: rtl/swk_row_unpack.sv
module swk_row_unpack #(
    parameter int ROW_W   = 256,
    parameter int ENTRY_W = 32,
    parameter int TGT_W   = 17,
    parameter int WGT_W   = 16,
    parameter int LANES   = ROW_W / ENTRY_W,
    parameter int LANE_W  = $clog2(LANES)
) (
    input  logic [ROW_W-1:0]  row_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic              is_syn_o,
    output logic              is_spk_o,
    output logic [TGT_W-1:0]  target_o,
    output logic [WGT_W-1:0]  weight_o
);
    logic [LANES-1:0]             syn_v;
    logic [LANES-1:0]             spk_v;
    logic [LANES-1:0][TGT_W-1:0]  tgt_v;
    logic [LANES-1:0][WGT_W-1:0]  wgt_v;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        swk_entry_decode #(
            .ENTRY_W (ENTRY_W),
            .TGT_W   (TGT_W),
            .WGT_W   (WGT_W)
        ) u_dec (
            .entry_i  (row_i[g*ENTRY_W +: ENTRY_W]),
            .is_syn_o (syn_v[g]),
            .is_spk_o (spk_v[g]),
            .target_o (tgt_v[g]),
            .weight_o (wgt_v[g])
        );
    end

    always_comb begin
        is_syn_o = syn_v[lane_i];
        is_spk_o = spk_v[lane_i];
        target_o = tgt_v[lane_i];
        weight_o = wgt_v[lane_i];
    end
endmodule

// File: rtl/swk_skip_ctr.sv
module swk_skip_ctr #(
    parameter int SKIP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [SKIP_W-1:0] count_o
);
    logic [SKIP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/swk_walk_ctrl.sv
module swk_walk_ctrl
    import swk_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int ADDR_W = 23,
    parameter int ROW_W  = 256,
    parameter int LANES  = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_valid_i,
    output logic              ptr_ready_o,
    input  logic [CNT_W-1:0]  ptr_cnt_i,
    input  logic [ADDR_W-1:0] ptr_start_i,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ADDR_W-1:0] rd_req_addr_o,
    input  logic              rd_rsp_valid_i,
    input  logic [ROW_W-1:0]  rd_rsp_data_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [LANE_W-1:0] lane_o,
    input  logic              lane_take_i,
    output logic              ev_valid_o,
    input  logic              ev_ready_i,
    output logic              skip_inc_o,
    output logic              done_o
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
    localparam logic [CNT_W-1:0]  ONE_ROW   = CNT_W'(1);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic [LANE_W-1:0] lane;
        logic [ROW_W-1:0]  row;
        logic              done;
    } ctl_t;

    ctl_t s_d, s_q;
    logic lane_adv;

    always_comb begin
        s_d            = s_q;
        s_d.done       = 1'b0;
        ptr_ready_o    = 1'b0;
        rd_req_valid_o = 1'b0;
        ev_valid_o     = 1'b0;
        skip_inc_o     = 1'b0;
        lane_adv       = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                ptr_ready_o = 1'b1;
                if (ptr_valid_i) begin
                    if (ptr_cnt_i == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st   = ST_REQ;
                        s_d.addr = ptr_start_i;
                        s_d.rem  = ptr_cnt_i;
                    end
                end
            end
            ST_REQ: begin
                rd_req_valid_o = 1'b1;
                if (rd_req_ready_i) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rd_rsp_valid_i) begin
                    s_d.row  = rd_rsp_data_i;
                    s_d.lane = '0;
                    s_d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                ev_valid_o = lane_take_i;
                skip_inc_o = !lane_take_i;
                lane_adv   = !lane_take_i || ev_ready_i;
                if (lane_adv) begin
                    if (s_q.lane == LAST_LANE) begin
                        if (s_q.rem == ONE_ROW) begin
                            s_d.st   = ST_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.rem  = s_q.rem - 1'b1;
                            s_d.addr = s_q.addr + 1'b1;
                            s_d.st   = ST_REQ;
                        end
                    end else begin
                        s_d.lane = s_q.lane + 1'b1;
                    end
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_addr_o = s_q.addr;
    assign row_o         = s_q.row;
    assign lane_o        = s_q.lane;
    assign done_o        = s_q.done;
endmodule

// File: rtl/syn_row_walker.sv
module syn_row_walker #(
    parameter int PTR_W   = 32,
    parameter int ADDR_W  = 23,
    parameter int ROW_W   = 256,
    parameter int ENTRY_W = 32,
    parameter int TGT_W   = 17,
    parameter int WGT_W   = 16,
    parameter int SKIP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ptr_valid,
    output logic               ptr_ready,
    input  logic [PTR_W-1:0]   ptr_word,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [ROW_W-1:0]   rd_rsp_data,
    output logic               ev_valid,
    input  logic               ev_ready,
    output logic               ev_kind,
    output logic [TGT_W-1:0]   ev_target,
    output logic [WGT_W-1:0]   ev_weight,
    output logic               walk_done,
    output logic [SKIP_W-1:0]  skip_count
);
    localparam int CNT_W  = PTR_W - ADDR_W;
    localparam int LANES  = ROW_W / ENTRY_W;
    localparam int LANE_W = $clog2(LANES);

    logic [CNT_W-1:0]  ptr_cnt;
    logic [ADDR_W-1:0] ptr_start;
    logic [ROW_W-1:0]  row_q;
    logic [LANE_W-1:0] lane_q;
    logic              lane_syn;
    logic              lane_spk;
    logic              skip_inc;

    assign ptr_cnt   = ptr_word[PTR_W-1:ADDR_W];
    assign ptr_start = ptr_word[ADDR_W-1:0];

    swk_walk_ctrl #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ptr_valid_i    (ptr_valid),
        .ptr_ready_o    (ptr_ready),
        .ptr_cnt_i      (ptr_cnt),
        .ptr_start_i    (ptr_start),
        .rd_req_valid_o (rd_req_valid),
        .rd_req_ready_i (rd_req_ready),
        .rd_req_addr_o  (rd_req_addr),
        .rd_rsp_valid_i (rd_rsp_valid),
        .rd_rsp_data_i  (rd_rsp_data),
        .row_o          (row_q),
        .lane_o         (lane_q),
        .lane_take_i    (lane_syn | lane_spk),
        .ev_valid_o     (ev_valid),
        .ev_ready_i     (ev_ready),
        .skip_inc_o     (skip_inc),
        .done_o         (walk_done)
    );

    swk_row_unpack #(
        .ROW_W   (ROW_W),
        .ENTRY_W (ENTRY_W),
        .TGT_W   (TGT_W),
        .WGT_W   (WGT_W),
        .LANES   (LANES),
        .LANE_W  (LANE_W)
    ) u_unpack (
        .row_i    (row_q),
        .lane_i   (lane_q),
        .is_syn_o (lane_syn),
        .is_spk_o (lane_spk),
        .target_o (ev_target),
        .weight_o (ev_weight)
    );

    assign ev_kind = lane_spk;

    swk_skip_ctr #(
        .SKIP_W (SKIP_W)
    ) u_skip (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (skip_inc),
        .count_o (skip_count)
    );
endmodule

// File: rtl/syn_row_walker_chk.sv
module syn_row_walker_chk #(
    parameter int TGT_W  = 17,
    parameter int WGT_W  = 16,
    parameter int SKIP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_valid,
    input logic              ptr_ready,
    input logic              rd_req_valid,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              ev_kind,
    input logic [TGT_W-1:0]  ev_target,
    input logic [WGT_W-1:0]  ev_weight,
    input logic              walk_done,
    input logic [SKIP_W-1:0] skip_count
);
    AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_target) && $stable(ev_weight))); // R10

    AST_NO_REQ_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && ev_valid)); // R9

    AST_IDLE_ONLY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ready |-> (!rd_req_valid && !ev_valid)); // R4

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> ($past(ptr_valid && ptr_ready) || $past(!rd_req_valid && !ptr_ready))); // R11

    AST_SKIP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (skip_count >= $past(skip_count))); // R8

    AST_SPIKE_NO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind) |-> (ev_weight == '0)); // R7
endmodule

bind syn_row_walker syn_row_walker_chk #(
    .TGT_W  (TGT_W),
    .WGT_W  (WGT_W),
    .SKIP_W (SKIP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_valid    (ptr_valid),
    .ptr_ready    (ptr_ready),
    .rd_req_valid (rd_req_valid),
    .ev_valid     (ev_valid),
    .ev_ready     (ev_ready),
    .ev_kind      (ev_kind),
    .ev_target    (ev_target),
    .ev_weight    (ev_weight),
    .walk_done    (walk_done),
    .skip_count   (skip_count)
);

// File: tb/syn_row_walker_tb.sv
module syn_row_walker_tb;
    localparam int CLK_P   = 10;
    localparam int RSP_LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ptr_valid = 1'b0;
    logic         ptr_ready;
    logic [31:0]  ptr_word = '0;
    logic         rd_req_valid;
    logic         rd_req_ready = 1'b1;
    logic [22:0]  rd_req_addr;
    logic         rd_rsp_valid = 1'b0;
    logic [255:0] rd_rsp_data = '0;
    logic         ev_valid;
    logic         ev_ready = 1'b1;
    logic         ev_kind;
    logic [16:0]  ev_target;
    logic [15:0]  ev_weight;
    logic         walk_done;
    logic [15:0]  skip_count;

    syn_row_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .ptr_valid(ptr_valid), .ptr_ready(ptr_ready), .ptr_word(ptr_word),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
        .ev_target(ev_target), .ev_weight(ev_weight),
        .walk_done(walk_done), .skip_count(skip_count)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [255:0] mem [0:15];
    logic [33:0]  got_ev [0:63];
    int           got_n = 0;
    logic [22:0]  req_log [0:15];
    int           req_n = 0;
    int           done_n = 0;
    int           done_cyc = 0;
    int           last_acc_cyc = 0;
    int           ptr_acc_cyc = 0;
    int           overlap_viol = 0;
    int           hold_viol = 0;
    logic         stall_en = 1'b0;
    logic         req_seen = 1'b0;
    logic [22:0]  req_addr_seen = '0;
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Monitor: samples at the falling edge, mid-cycle
    initial begin
        logic        prev_hold;
        logic [33:0] prev_ev;
        prev_hold = 1'b0;
        prev_ev   = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_hold && !(ev_valid && {ev_kind, ev_target, ev_weight} == prev_ev)) hold_viol++;
                prev_hold = ev_valid && !ev_ready;
                prev_ev   = {ev_kind, ev_target, ev_weight};
                if (ev_valid && ev_ready) begin
                    if (got_n < 64) got_ev[got_n] = {ev_kind, ev_target, ev_weight};
                    got_n++;
                    last_acc_cyc = cyc;
                end
                if (rd_req_valid && ev_valid) overlap_viol++;
                if (rd_req_valid && rd_req_ready) begin
                    if (req_n < 16) req_log[req_n] = rd_req_addr;
                    req_n++;
                    req_seen = 1'b1;
                    req_addr_seen = rd_req_addr;
                end
                if (walk_done) begin
                    done_n++;
                    done_cyc = cyc;
                end
            end
        end
    end

    // Memory responder: fixed latency, one cycle of response valid
    initial begin
        int wait_cnt;
        logic [22:0] paddr;
        wait_cnt = 0;
        paddr = '0;
        forever begin
            @(posedge clk);
            #1;
            rd_rsp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = mem[paddr[3:0]];
                end
            end
            if (req_seen) begin
                req_seen = 1'b0;
                paddr    = req_addr_seen;
                wait_cnt = RSP_LAT;
            end
        end
    end

    // Downstream throttle
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ev_ready = stall_en ? lfsr[0] : 1'b1;
    end

    function automatic logic [31:0] syn_e(input logic [12:0] t, input logic [15:0] w);
        return {3'b000, t, w};
    endfunction

    function automatic logic [31:0] spk_e(input logic [16:0] n);
        return {3'b100, 12'h000, n};
    endfunction

    // Expected event per R6/R7/R8: bit 34 = emitted
    function automatic logic [34:0] exp_dec(input logic [31:0] e);
        if (e[31:29] == 3'b000) return {1'b1, 1'b0, 4'b0000, e[28:16], e[15:0]};
        if (e[31:29] == 3'b100 && e[28:17] == 12'h000) return {1'b1, 1'b1, e[16:0], 16'h0000};
        return '0;
    endfunction

    task automatic send_ptr(input logic [31:0] p);
        @(posedge clk);
        #1;
        ptr_valid = 1'b1;
        ptr_word  = p;
        @(negedge clk);
        while (!ptr_ready) @(negedge clk);
        ptr_acc_cyc = cyc;
        @(posedge clk);
        #1;
        ptr_valid = 1'b0;
    endtask

    task automatic run_ptr(input logic [31:0] p, input string name);
        int cnt, exp_n, exp_skip, t;
        logic [15:0] skip0;
        logic [34:0] d;
        logic [33:0] exp_ev [0:63];
        logic last_is_ev;
        got_n = 0; req_n = 0; done_n = 0;
        skip0 = skip_count;
        send_ptr(p);
        if (p[31:23] != 0) begin
            @(negedge clk);
            chk(ptr_ready == 1'b0, {name, " R4 ptr_ready while busy"}, ptr_ready, 0);
        end
        t = 0;
        while (done_n == 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        cnt = p[31:23];
        exp_n = 0; exp_skip = 0; last_is_ev = 1'b0;
        for (int r = 0; r < cnt; r++) begin
            for (int l = 0; l < 8; l++) begin
                d = exp_dec(mem[(p[3:0] + r) % 16][l*32 +: 32]);
                if (d[34]) begin exp_ev[exp_n] = d[33:0]; exp_n++; end
                else exp_skip++;
                last_is_ev = d[34];
            end
        end
        chk(req_n == cnt, {name, " R2 read count"}, req_n, cnt);
        for (int i = 0; i < req_n && i < cnt; i++)
            chk(req_log[i] == p[22:0] + 23'(i), {name, " R2 read address"}, req_log[i], p[22:0] + 23'(i));
        chk(got_n == exp_n, {name, " R5 event count"}, got_n, exp_n);
        for (int i = 0; i < got_n && i < exp_n; i++)
            chk(got_ev[i] == exp_ev[i],
                exp_ev[i][33] ? {name, " R7 spike event / R5 order"} : {name, " R6 synapse event / R5 order"},
                got_ev[i], exp_ev[i]);
        chk(skip_count - skip0 == 16'(exp_skip), {name, " R8 skip count delta"}, skip_count - skip0, exp_skip);
        chk(done_n == 1, {name, " R11 single done pulse"}, done_n, 1);
        if (cnt == 0)
            chk(done_cyc == ptr_acc_cyc + 1, {name, " R3 done after zero-count pointer"}, done_cyc, ptr_acc_cyc + 1);
        else if (last_is_ev)
            chk(done_cyc == last_acc_cyc + 1, {name, " R11 done timing"}, done_cyc, last_acc_cyc + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ptr_ready == 1'b1, "R1 ptr_ready after reset", ptr_ready, 1);
        chk(rd_req_valid == 1'b0, "R1 rd_req_valid after reset", rd_req_valid, 0);
        chk(ev_valid == 1'b0, "R1 ev_valid after reset", ev_valid, 0);
        chk(walk_done == 1'b0, "R1 walk_done after reset", walk_done, 0);
        chk(skip_count == 16'd0, "R1 skip_count after reset", skip_count, 0);
    endtask

    task automatic t_single_row();
        for (int l = 0; l < 8; l++) mem[2][l*32 +: 32] = syn_e(13'(16'h100 + l), 16'(16'h1000 + 3*l));
        stall_en = 1'b0;
        run_ptr({9'd1, 23'h008002}, "single row");
    endtask

    task automatic t_mixed_row();
        mem[3] = {syn_e(13'd5, 16'd7), spk_e(17'd0), 32'hE000_0001, syn_e(13'd0, 16'd0),
                  {3'b100, 12'h001, 17'h00055}, 32'h2345_6789, spk_e(17'h1ABCD), syn_e(13'h1FFF, 16'hFFFF)};
        stall_en = 1'b1;
        run_ptr({9'd1, 23'h008003}, "mixed row R8");
    endtask

    task automatic t_multi_row();
        mem[5] = {spk_e(17'h10000), 32'h6000_0000, syn_e(13'h0AA, 16'h8001), syn_e(13'h0AB, 16'h8002),
                  syn_e(13'h0AC, 16'h8003), 32'hA000_0000, syn_e(13'h0AD, 16'h0004), spk_e(17'h00001)};
        for (int l = 0; l < 8; l++) mem[6][l*32 +: 32] = 32'hFFFF_FFFF;
        for (int l = 0; l < 8; l++) mem[7][l*32 +: 32] = (l % 2) ? spk_e(17'(l)) : syn_e(13'(l), 16'(l * 11));
        stall_en = 1'b1;
        run_ptr({9'd3, 23'h008005}, "three rows R9");
    endtask

    task automatic t_zero_count();
        stall_en = 1'b0;
        run_ptr({9'd0, 23'h008000}, "zero count R3");
    endtask

    task automatic t_wrap_rows();
        for (int l = 0; l < 8; l++) mem[15][l*32 +: 32] = syn_e(13'(l + 40), 16'(l + 100));
        for (int l = 0; l < 8; l++) mem[0][l*32 +: 32]  = spk_e(17'(17'h1FF00 + l));
        stall_en = 1'b0;
        run_ptr({9'd2, 23'h00800F}, "address step R2");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single_row();
        t_mixed_row();
        t_multi_row();
        t_zero_count();
        t_wrap_rows();
        chk(overlap_viol == 0, "R9 read request during pending event", overlap_viol, 0);
        chk(hold_viol == 0, "R10 event changed while stalled", hold_viol, 0);
        finish_sim();
    end
endmodule